// File: doc/BRIEF.md
# Staged Barrel Shifter

This block moves a 32-bit word by any distance from 0 to 31 positions in a single combinational pass. Four operations are available: logical left, logical right, arithmetic right and rotate right. It also reports the last bit that left the word, so that a datapath can use that bit as its carry flag.

The shift runs through a chain of fixed-distance stages. Their distances are 1, 2, 4, 8 and 16 positions. Each bit of the amount switches exactly one stage on. An enabled stage applies its distance using the selected operation's fill rule. A disabled stage forwards its input unchanged. Because every stage uses the same fill rule, the chain as a whole gives the same result as one shift by the full amount.

The block holds no state. Its outputs follow its inputs within the same evaluation, with no clock or reset. It is meant to sit in an execute stage between the register read and the ALU operand input.

Top module: `barrel_shift32`

## Requirements
- R1: With an amount of 0, `data_o` equals `data_i` and `carry_o` equals `carry_i` for every operation code.
- R2: Operation code 2'b00 (logical left) gives `data_i` shifted left by the amount, with the vacated low bits set to 0.
- R3: Operation code 2'b01 (logical right) gives `data_i` shifted right by the amount, with the vacated high bits set to 0.
- R4: Operation code 2'b10 (arithmetic right) gives `data_i` shifted right by the amount, with every vacated high bit equal to bit 31 of `data_i`.
- R5: Operation code 2'b11 (rotate right) gives `data_i` rotated right by the amount. Bits leaving bit 0 re-enter at bit 31, so the number of set bits is preserved.
- R6: For a non-zero amount, `carry_o` is the last bit shifted out. For a left shift by n, that is `data_i[32-n]`. For the three right operations, it is `data_i[n-1]`.
- R7: Each amount bit k (0 to 4) enables one stage of distance 2^k. Shifting by an amount equals shifting in sequence by the powers of two that make it up. For example, 25 equals 1, then 8, then 16.
- R8: The outputs are a pure function of the current inputs. A change at the inputs appears at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Operand to be shifted |
| amount_i | input | 5 | Shift distance, 0 to 31 |
| op_i | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Incoming carry, returned when the amount is 0 |
| data_o | output | 32 | Shifted result |
| carry_o | output | 1 | Last bit shifted out, or `carry_i` for amount 0 |

## Verification
The bench builds the block with its default width of 32, which gives a 5-bit amount and five stages. With these values, every one of the 32 amounts can be applied under all four operation codes, so each stage is exercised both enabled and bypassed under every fill rule. The sign-fill and rotate wrap-around are checked at the extreme amounts 1 and 31. The stage decomposition is checked by feeding the output back as the next input. Operands include all-zero, all-one and alternating patterns, values with a set and a clear top bit, and pseudo-random words.

// File: rtl/barrel_shift_pkg.sv
// Package: shared operation encoding for the staged shifter.
// Assumes the two-bit code space is fully used by four operations.
package barrel_shift_pkg;

    typedef enum logic [1:0] {
        OP_SHL = 2'b00,   // logical left, zero fill
        OP_SHR = 2'b01,   // logical right, zero fill
        OP_SAR = 2'b10,   // arithmetic right, sign fill
        OP_ROT = 2'b11    // rotate right
    } shift_op_e;

endpackage

// File: rtl/shift_fill_gen.sv
// Module: shift_fill_gen
// Picks the bit that right-shifting stages insert at the top.
// For arithmetic right this is the sign of the original operand.
// For every other operation it is 0; left shifts and rotates ignore it.
module shift_fill_gen
    import barrel_shift_pkg::*;
(
    input  shift_op_e op_i,
    input  logic      sign_i,
    output logic      fill_o
);

    // Fill is the operand sign only for arithmetic right.
    always_comb begin
        fill_o = (op_i == OP_SAR) ? sign_i : 1'b0;
    end

endmodule

// File: rtl/shift_stage.sv
// Module: shift_stage
// One fixed-distance stage of the cascade.
// When enabled, it shifts its input by DIST using the selected operation and
// reports the last bit it pushed out. When disabled, it forwards both the
// data and the incoming carry unchanged.
// Assumes 0 < DIST < WIDTH.
module shift_stage
    import barrel_shift_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic             en_i,
    input  shift_op_e        op_i,
    input  logic             fill_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] d_o,
    output logic             c_o
);

    logic [WIDTH-1:0] moved;
    logic             lost_bit;

    // Form the shifted word and the bit that leaves it, per operation.
    always_comb begin
        unique case (op_i)
            OP_SHL: begin
                moved    = {d_i[WIDTH-DIST-1:0], {DIST{1'b0}}};
                lost_bit = d_i[WIDTH-DIST];
            end
            OP_SHR: begin
                moved    = {{DIST{1'b0}}, d_i[WIDTH-1:DIST]};
                lost_bit = d_i[DIST-1];
            end
            OP_SAR: begin
                moved    = {{DIST{fill_i}}, d_i[WIDTH-1:DIST]};
                lost_bit = d_i[DIST-1];
            end
            default: begin
                moved    = {d_i[DIST-1:0], d_i[WIDTH-1:DIST]};
                lost_bit = d_i[DIST-1];
            end
        endcase
    end

    // Apply the stage or bypass it, according to its amount bit.
    always_comb begin
        d_o = en_i ? moved    : d_i;
        c_o = en_i ? lost_bit : c_i;
    end

endmodule

// File: rtl/barrel_shift32.sv
// Module: barrel_shift32
// Combinational staged barrel shifter.
// Stage k shifts by 2**k and is enabled by bit k of the amount. Every stage
// uses one shared operation and fill bit, so the cascade equals one shift by
// the full amount. The carry is the last bit dropped by the last enabled
// stage, or the incoming carry when no stage is enabled.
// Assumes WIDTH is a power of two, at least 2.
module barrel_shift32
    import barrel_shift_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic [1:0]       op_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] data_o,
    output logic             carry_o
);

    shift_op_e        op;
    logic             fill;
    logic [WIDTH-1:0] chain_d [AMT_W+1];
    logic             chain_c [AMT_W+1];

    // Decode the raw code into the shared operation type.
    always_comb begin
        op = shift_op_e'(op_i);
    end

    shift_fill_gen u_fill (
        .op_i   (op),
        .sign_i (data_i[WIDTH-1]),
        .fill_o (fill)
    );

    // Seed the head of the cascade with the operand and incoming carry.
    always_comb begin
        chain_d[0] = data_i;
        chain_c[0] = carry_i;
    end

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        shift_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << k)
        ) u_stage (
            .en_i   (amount_i[k]),
            .op_i   (op),
            .fill_i (fill),
            .d_i    (chain_d[k]),
            .c_i    (chain_c[k]),
            .d_o    (chain_d[k+1]),
            .c_o    (chain_c[k+1])
        );
    end

    // Take the result from the tail of the cascade.
    always_comb begin
        data_o  = chain_d[AMT_W];
        carry_o = chain_c[AMT_W];
    end

    // Guard the port-level relations of the finished cascade.
    always_comb begin
        if (amount_i == '0) begin
            p_zero_pass_r1: assert (data_o == data_i && carry_o == carry_i)
                else $error("amount 0 must pass data and carry");
        end
        if (amount_i != '0 && op == OP_SHL) begin
            p_shl_low_zero_r2: assert (data_o[0] == 1'b0)
                else $error("left shift must clear bit 0");
        end
        if (amount_i != '0 && op == OP_SHR) begin
            p_shr_top_zero_r3: assert (data_o[WIDTH-1] == 1'b0)
                else $error("logical right must clear the top bit");
        end
        if (op == OP_SAR) begin
            p_sar_sign_kept_r4: assert (data_o[WIDTH-1] == data_i[WIDTH-1])
                else $error("arithmetic right must keep the sign");
        end
        if (op == OP_ROT) begin
            p_rot_ones_kept_r5: assert ($countones(data_o) == $countones(data_i))
                else $error("rotate must preserve the set-bit count");
            if (amount_i != '0) begin
                p_rot_carry_top_r6: assert (carry_o == data_o[WIDTH-1])
                    else $error("rotate carry must equal the new top bit");
            end
        end
    end

endmodule

// File: tb/tb_barrel_shift32.sv
// Bench: directed scenarios against a reference computed from the requirements.
module tb_barrel_shift32;

    logic        clk;
    logic        rst_n;
    logic [31:0] data_i;
    logic [4:0]  amount_i;
    logic [1:0]  op_i;
    logic        carry_i;
    logic [31:0] data_o;
    logic        carry_o;

    int checks;
    int failures;
    bit done;

    barrel_shift32 dut (
        .data_i   (data_i),
        .amount_i (amount_i),
        .op_i     (op_i),
        .carry_i  (carry_i),
        .data_o   (data_o),
        .carry_o  (carry_o)
    );

    // 125 MHz bench clock paces the stimulus.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Compare a result with its expected value and count the outcome.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirement text.
    task automatic ref_shift(input logic [31:0] d, input int n, input logic [1:0] op,
                             input logic cin, output logic [31:0] r, output logic c);
        if (n == 0) begin
            r = d;
            c = cin;
        end else begin
            case (op)
                2'b00: begin r = d << n; c = d[32-n]; end
                2'b01: begin r = d >> n; c = d[n-1]; end
                2'b10: begin r = 32'($signed(d) >>> n); c = d[n-1]; end
                default: begin r = (d >> n) | (d << (32 - n)); c = d[n-1]; end
            endcase
        end
    endtask

    // Drive one input set away from the clock edge and let it settle.
    task automatic apply(input logic [31:0] d, input int n, input logic [1:0] op, input logic cin);
        @(negedge clk);
        data_i   = d;
        amount_i = 5'(n);
        op_i     = op;
        carry_i  = cin;
        #1;
    endtask

    // Check both outputs against the reference for one input set.
    task automatic apply_and_check(input logic [31:0] d, input int n, input logic [1:0] op,
                                   input logic cin, input string req);
        logic [31:0] er;
        logic        ec;
        apply(d, n, op, cin);
        ref_shift(d, n, op, cin, er, ec);
        chk(req, data_o, er);
        chk(n == 0 ? "R1 carry" : "R6 carry", {31'b0, carry_o}, {31'b0, ec});
    endtask

    // Reset state: zero inputs after reset give zero outputs.
    task automatic test_reset_state();
        @(negedge clk);
        chk("R8 reset data", data_o, 32'h0);
        chk("R8 reset carry", {31'b0, carry_o}, 32'h0);
    endtask

    // R1: amount 0 passes data and carry for every operation.
    task automatic test_zero_amount();
        for (int op = 0; op < 4; op++) begin
            apply_and_check(32'h8000_0001, 0, 2'(op), 1'b1, "R1 data");
            apply_and_check(32'h7FFF_FFFE, 0, 2'(op), 1'b0, "R1 data");
        end
    endtask

    // R2-R5 and R6: all amounts, all operations, fixed patterns.
    task automatic test_sweep();
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hAAAA_5555;
        pats[3] = 32'h8000_0000; pats[4] = 32'h0000_0001; pats[5] = 32'h7F00_00F1;
        for (int op = 0; op < 4; op++)
            for (int n = 1; n < 32; n++)
                for (int p = 0; p < 6; p++)
                    apply_and_check(pats[p], n, 2'(op), 1'b0,
                                    op == 0 ? "R2" : op == 1 ? "R3" : op == 2 ? "R4" : "R5");
    endtask

    // R4/R5 extremes: sign fill and wrap at distances 1 and 31.
    task automatic test_extremes();
        apply(32'h8000_0000, 31, 2'b10, 1'b0);
        chk("R4 sar31 negative", data_o, 32'hFFFF_FFFF);
        apply(32'h7FFF_FFFF, 31, 2'b10, 1'b0);
        chk("R4 sar31 positive", data_o, 32'h0000_0000);
        apply(32'h0000_0001, 1, 2'b11, 1'b0);
        chk("R5 rot1 wrap", data_o, 32'h8000_0000);
        chk("R6 rot1 carry", {31'b0, carry_o}, 32'h1);
        apply(32'h0000_0001, 31, 2'b00, 1'b0);
        chk("R2 shl31", data_o, 32'h8000_0000);
        apply(32'h8000_0000, 1, 2'b00, 1'b0);
        chk("R6 shl1 carry", {31'b0, carry_o}, 32'h1);
    endtask

    // Random operands across all amounts and operations.
    task automatic test_random();
        for (int i = 0; i < 400; i++)
            apply_and_check($urandom, i % 32, 2'(i / 100), 1'($urandom),
                            "R2-5 random");
    endtask

    // R7: 25 in one pass equals 1, then 8, then 16 fed back.
    task automatic test_compose();
        logic [31:0] one_pass;
        logic [31:0] step;
        for (int op = 0; op < 4; op++) begin
            apply(32'hC3A5_0F96, 25, 2'(op), 1'b0);
            one_pass = data_o;
            apply(32'hC3A5_0F96, 1, 2'(op), 1'b0);
            step = data_o;
            // Arithmetic right keeps the sign; the fed-back word has the same top bit.
            apply(step, 8, 2'(op), 1'b0);
            step = data_o;
            apply(step, 16, 2'(op), 1'b0);
            chk("R7 compose 25", data_o, one_pass);
        end
    endtask

    // R8: outputs follow an input change with no clock edge in between.
    task automatic test_comb();
        @(negedge clk);
        data_i = 32'h0000_00F0; amount_i = 5'd4; op_i = 2'b01; carry_i = 1'b0;
        #1;
        chk("R8 settle a", data_o, 32'h0000_000F);
        amount_i = 5'd8;
        #1;
        chk("R8 settle b", data_o, 32'h0000_0000);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        checks = 0; failures = 0; done = 1'b0;
        rst_n = 1'b0;
        data_i = '0; amount_i = '0; op_i = '0; carry_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset_state();
        test_zero_amount();
        test_sweep();
        test_extremes();
        test_random();
        test_compose();
        test_comb();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule